// File: doc/BRIEF.md
# Four-Wire Serial Word EEPROM Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host drives chip select, a serial clock and a serial data input. The block returns read data on a serial data output. The device runs on a fast system clock. It oversamples the serial clock and acts on each low-to-high transition of that clock while chip select is high. Each instruction begins with a 1 start bit, followed by a two-bit opcode and then an address field. The address field is `ADDR_BITS` wide, and the parameter may be 6 or 8. Some instructions then take a 16-bit data field.

The supported operations are: read one word, write one word, erase one word, erase every word, write every word with the same value, and the instructions that set and clear a programming-enable latch. Programming takes effect one system clock after the last bit of the instruction. There is no busy phase. The block is meant as a partner for a host-side controller in simulation, and it can also be checked on its own.

The serial pins carry no valid/ready handshake and have no back-pressure. The host paces every bit with the serial clock, and the device must keep up with that pace. Dropping chip select is the only way to end or abandon a transfer.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high and the device is idle, serial clock rises that sample a 0 on data in are ignored. The first sampled 1 is the start bit.
- R2: Opcode bits 1,0 (in that order) read the addressed word. On the rise that samples the last address bit, data out goes to 0, which is a dummy bit. Each of the next 16 rises then launches one word bit, bit 15 first and bit 0 last.
- R3: Opcode bits 0,1 followed by 16 data bits (bit 15 first) store the data at the address, provided programming is enabled.
- R4: Opcode bits 1,1 set the addressed word to 16'hFFFF, provided programming is enabled.
- R5: Opcode bits 0,0 with the two top address bits 1,1 enable programming. The remaining address bits are ignored.
- R6: Opcode 0,0 with top address bits 1,0 sets every word to 16'hFFFF, provided programming is enabled.
- R7: Opcode 0,0 with top address bits 0,1, followed by 16 data bits, writes that value to every word, provided programming is enabled.
- R8: The programming latch is cleared by reset. A write, erase, erase-all or write-all received while the latch is clear changes no word.
- R9: Opcode 0,0 with top address bits 0,0 clears the programming latch, so later programming instructions are ignored again.
- R10: Dropping chip select abandons any partial instruction and forces data out to 0. Data out is 0 whenever no read is in progress.
- R11: After reset every word reads 16'hFFFF. The address field is `ADDR_BITS` wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data into the device |
| do_o | output | 1 | Serial data out of the device |

## Verification
The bench targets the following failure cases:
- **Leading zeros before the start bit.** A decoder that treats the first bit as the start bit would misparse the instruction.
- **The dummy bit ahead of read data.** A design that launches bit 15 one rise too early would shift every captured word by one place.
- **Programming before enable, and after disable.** A missing latch check would show up as a changed word when the address is read back.
- **An instruction abandoned mid-address.** Without the abort, a stale partial instruction would corrupt a word or leave data out high.
- **The extended opcode split across the top address bits.** A wrong bit choice would swap erase-all and write-all, or the enable and disable instructions. This shows up in words at the array's first, middle and last addresses.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } mw_state_e;

  typedef enum logic [2:0] {
    PG_NONE,
    PG_WR_ONE,
    PG_WR_ALL,
    PG_ER_ONE,
    PG_ER_ALL
  } pg_op_e;
endpackage

// File: rtl/mw_sk_edge.sv
module mw_sk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk_i,
  output logic sk_rise
);
  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk_i;
  end

  assign sk_rise = sk_i & ~sk_q;
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array
  import mw_pkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pg_op_e               pg_op,
  input  logic [ADDR_BITS-1:0] pg_addr,
  input  logic [WORD_W-1:0]    pg_data,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [WORD_W-1:0]    rd_word
);
  localparam int WORDS = 1 << ADDR_BITS;
  localparam logic [WORD_W-1:0] ERASED = '1;

  logic [WORD_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = (pg_addr == ADDR_BITS'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[w] <= ERASED;
      else begin
        unique case (pg_op)
          PG_WR_ONE: if (hit) mem[w] <= pg_data;
          PG_ER_ONE: if (hit) mem[w] <= ERASED;
          PG_WR_ALL: mem[w] <= pg_data;
          PG_ER_ALL: mem[w] <= ERASED;
          default:   ;
        endcase
      end
    end
  end

  assign rd_word = mem[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_op == PG_WR_ONE) |=> mem[$past(pg_addr)] == $past(pg_data)); // R3
  AST_ERASE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_op == PG_ER_ONE) |=> mem[$past(pg_addr)] == ERASED); // R4
  AST_ERASE_ALL_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_op == PG_ER_ALL) |=> (mem[0] == ERASED && mem[WORDS-1] == ERASED)); // R6
  AST_WRITE_ALL_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_op == PG_WR_ALL) |=> (mem[0] == $past(pg_data) && mem[WORDS-1] == $past(pg_data))); // R7
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_i,
  input  logic                 di_i,
  input  logic                 sk_rise,
  input  logic [WORD_W-1:0]    rd_word,
  output pg_op_e               pg_op,
  output logic [ADDR_BITS-1:0] addr,
  output logic [WORD_W-1:0]    data_sh,
  output logic                 dout
);
  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);

  mw_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [1:0]           opc;
  logic                 we_en;
  logic                 loaded;
  logic [WORD_W-1:0]    rd_sh;
  logic [ADDR_BITS-1:0] addr_nxt;
  logic [1:0]           ext_sel;

  assign addr_nxt = {addr[ADDR_BITS-2:0], di_i};
  assign ext_sel  = addr_nxt[ADDR_BITS-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      opc     <= '0;
      addr    <= '0;
      data_sh <= '0;
      we_en   <= 1'b0;
      loaded  <= 1'b0;
      rd_sh   <= '0;
      dout    <= 1'b0;
      pg_op   <= PG_NONE;
    end else begin
      pg_op <= PG_NONE;
      if (!cs_i) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        loaded <= 1'b0;
        dout   <= 1'b0;
      end else begin
        if (state == ST_READ && !loaded) begin
          rd_sh  <= rd_word;
          loaded <= 1'b1;
        end
        if (sk_rise) begin
          unique case (state)
            ST_IDLE: if (di_i) begin
              state <= ST_OPC;
              cnt   <= '0;
            end
            ST_OPC: begin
              opc <= {opc[0], di_i};
              if (cnt == CNT_W'(1)) begin
                state <= ST_ADDR;
                cnt   <= '0;
              end else cnt <= cnt + 1'b1;
            end
            ST_ADDR: begin
              addr <= addr_nxt;
              cnt  <= cnt + 1'b1;
              if (cnt == ADDR_LAST) begin
                cnt   <= '0;
                state <= ST_HOLD;
                unique case (opc)
                  2'b10: begin
                    state  <= ST_READ;
                    loaded <= 1'b0;
                    dout   <= 1'b0;
                  end
                  2'b01: state <= ST_DATA;
                  2'b11: if (we_en) pg_op <= PG_ER_ONE;
                  default: begin
                    unique case (ext_sel)
                      2'b11: we_en <= 1'b1;
                      2'b00: we_en <= 1'b0;
                      2'b10: if (we_en) pg_op <= PG_ER_ALL;
                      default: state <= ST_DATA;
                    endcase
                  end
                endcase
              end
            end
            ST_DATA: begin
              data_sh <= {data_sh[WORD_W-2:0], di_i};
              cnt     <= cnt + 1'b1;
              if (cnt == DATA_LAST) begin
                state <= ST_HOLD;
                if (we_en) pg_op <= (opc == 2'b01) ? PG_WR_ONE : PG_WR_ALL;
              end
            end
            ST_READ: begin
              dout  <= rd_sh[WORD_W-1];
              rd_sh <= {rd_sh[WORD_W-2:0], 1'b0};
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> (state == ST_IDLE && !dout)); // R10
  AST_DUMMY_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_READ) |-> !dout); // R2
  AST_PROG_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_op != PG_NONE) |-> we_en); // R8
  AST_QUIET_UNLESS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_READ && $past(state) != ST_READ) |-> !dout); // R10
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  logic                 sk_rise;
  pg_op_e               pg_op;
  logic [ADDR_BITS-1:0] addr;
  logic [WORD_W-1:0]    data_sh;
  logic [WORD_W-1:0]    rd_word;

  mw_sk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sk_i    (sk_i),
    .sk_rise (sk_rise)
  );

  mw_cmd_decoder #(.ADDR_BITS(ADDR_BITS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs_i),
    .di_i    (di_i),
    .sk_rise (sk_rise),
    .rd_word (rd_word),
    .pg_op   (pg_op),
    .addr    (addr),
    .data_sh (data_sh),
    .dout    (do_o)
  );

  mw_word_array #(.ADDR_BITS(ADDR_BITS)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pg_op   (pg_op),
    .pg_addr (addr),
    .pg_data (data_sh),
    .rd_addr (addr),
    .rd_word (rd_word)
  );
endmodule

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int AB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [16:0] exp_q[$];
  logic [16:0] obs_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mw_eeprom #(.ADDR_BITS(AB)) u_mw_eeprom (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_i  (cs),
    .sk_i  (sk),
    .di_i  (di),
    .do_o  (dout)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic o);
    di = b;
    sk = 1'b0;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (3) @(negedge clk);
    o = dout;
  endtask

  task automatic hdr(input int lead, input logic [1:0] op, input logic [AB-1:0] a, output logic o);
    cs = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < lead; i++) pulse(1'b0, o);
    pulse(1'b1, o);
    pulse(op[1], o);
    pulse(op[0], o);
    for (int i = AB - 1; i >= 0; i--) pulse(a[i], o);
  endtask

  task automatic end_cmd();
    sk = 1'b0;
    repeat (2) @(negedge clk);
    cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // driver: read pushes the expected item, the captured bits go to the monitor
  task automatic rd(input logic [AB-1:0] a, input logic [15:0] exp, input string req);
    logic o;
    logic [16:0] v;
    hdr(0, 2'b10, a, o);
    v[16] = o;
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0, o);
      v[i] = o;
    end
    end_cmd();
    exp_q.push_back({1'b0, exp});
    tag_q.push_back(req);
    obs_q.push_back(v);
  endtask

  task automatic wr(input int lead, input logic [1:0] op, input logic [AB-1:0] a,
                    input logic [15:0] d, output logic saw_hi);
    logic o;
    hdr(lead, op, a, o);
    saw_hi = o;
    for (int i = 15; i >= 0; i--) begin
      pulse(d[i], o);
      saw_hi = saw_hi | o;
    end
    end_cmd();
  endtask

  task automatic ext(input logic [1:0] code);
    logic o;
    hdr(0, 2'b00, {code, {(AB-2){1'b0}}}, o);
    end_cmd();
  endtask

  task automatic erase1(input logic [AB-1:0] a);
    logic o;
    hdr(0, 2'b11, a, o);
    end_cmd();
  endtask

  // monitor: compares captured read frames against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [16:0] got;
        logic [16:0] want;
        string t;
        got  = obs_q.pop_front();
        want = exp_q.pop_front();
        t    = tag_q.pop_front();
        check(t, got, want);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic hi;
    logic o;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 reset dout", {16'b0, dout}, 17'h0);
    rd(6'd5, 16'hFFFF, "R11 erased after reset");

    wr(0, 2'b01, 6'd3, 16'hA5C3, hi);
    rd(6'd3, 16'hFFFF, "R8 write ignored while latch clear");

    ext(2'b11);
    wr(0, 2'b01, 6'd3, 16'hA5C3, hi);
    check("R10 dout low during write", {16'b0, hi}, 17'h0);
    rd(6'd3, 16'hA5C3, "R3 write then R2 read");
    wr(0, 2'b01, 6'd63, 16'h1234, hi);
    rd(6'd63, 16'h1234, "R3 top address");

    wr(2, 2'b01, 6'd10, 16'h0F0F, hi);
    rd(6'd10, 16'h0F0F, "R1 leading zeros skipped");

    erase1(6'd3);
    rd(6'd3, 16'hFFFF, "R4 erase word");
    rd(6'd63, 16'h1234, "R4 neighbour intact");

    cs = 1'b1;
    repeat (2) @(negedge clk);
    pulse(1'b1, o);
    pulse(1'b0, o);
    pulse(1'b1, o);
    pulse(1'b1, o);
    pulse(1'b0, o);
    pulse(1'b1, o);
    end_cmd();
    check("R10 dout after abort", {16'b0, dout}, 17'h0);
    rd(6'd10, 16'h0F0F, "R10 aborted write left word");

    wr(0, 2'b00, {2'b01, 4'b0}, 16'h5A5A, hi);
    rd(6'd0, 16'h5A5A, "R7 write all low");
    rd(6'd17, 16'h5A5A, "R7 write all mid");
    rd(6'd63, 16'h5A5A, "R7 write all high");

    ext(2'b10);
    rd(6'd0, 16'hFFFF, "R6 erase all low");
    rd(6'd63, 16'hFFFF, "R6 erase all high");

    ext(2'b00);
    wr(0, 2'b01, 6'd2, 16'h1111, hi);
    rd(6'd2, 16'hFFFF, "R9 write blocked after disable");
    wr(0, 2'b00, {2'b01, 4'b0}, 16'h2222, hi);
    rd(6'd40, 16'hFFFF, "R9 write all blocked after disable");

    ext(2'b11);
    wr(0, 2'b01, 6'd2, 16'h8001, hi);
    rd(6'd2, 16'h8001, "R5 enable again");

    wait (obs_q.size() == 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule